// File: doc/BRIEF.md
# Dual Read Line Buffer Controller

This block sits between a bus read port and a slow flash array. It keeps two 32-byte read line buffers. One buffer is tied to the lower half of the array and the other to the upper half. For every read it checks the buffer that belongs to the half being addressed. If the stored line matches and is valid, the word comes back after one clock. Otherwise the block asks the array for the whole aligned line and waits a number of clocks set by a 2-bit wait-state code. It then returns the word and keeps the line, so later reads inside that line are fast.

Two control events make buffered lines stale. The first is any change, rising or falling, of the high-voltage enable level: it drops both buffers. The second is a program or erase interlock write: it drops only the buffer holding the written line. If either event reaches the line that is being fetched, the requester still gets its word, but the line is not kept.

The controller runs as a three-state machine. IDLE waits for a request and looks up the buffer. FETCH counts wait states while the array line request is raised. RESP presents the data for one cycle. The transitions are named as follows:

- IDLE to RESP on a hit.
- IDLE to FETCH on a miss.
- FETCH to FETCH while the wait count is non-zero.
- FETCH to RESP when the count reaches zero and the line is captured.
- RESP to IDLE unconditionally.

Top module: `dual_line_buf_ctrl`

## Requirements
- R1: After reset, rd_ready and arr_req are low and both buffers are invalid, so the first read of any line is a miss.
- R2: Address bit 17 selects the buffer: 0 selects the lower buffer and 1 selects the upper buffer. The stored tag is address bits 17:5. Reads that differ only in bit 17 therefore use different buffers, and a new line in one half replaces the line previously held for that half.
- R3: A miss accepted on clock edge e0 with wait code w (00, 01, 10, 11) raises rd_ready in the cycle that follows edge e0+w+1. The total latency is therefore w+2 clocks, from 2 to 5.
- R4: A hit accepted on edge e0 raises rd_ready in the cycle right after e0, which is a latency of one clock.
- R5: rd_data is the 32-bit word selected by address bits 4:2. Word i of a line occupies bits 32*i+31:32*i of arr_line_data.
- R6: During a fetch, arr_req is high for exactly w+1 cycles and is never high together with rd_ready. arr_line_addr equals the tag of the missed line while arr_req is high. A hit never raises arr_req.
- R7: A fill of one buffer leaves the valid state and contents of the other buffer unchanged.
- R8: Any change of hv_en, in either direction, invalidates both buffers from the next edge on.
- R9: An ilk_wr pulse invalidates only the buffer whose valid tag equals ilk_addr bits 17:5. The other buffer, and any non-matching line, keep hitting.
- R10: If hv_en changes, or an ilk_wr to the pending line occurs, during FETCH (up to and including the capture edge), the read still completes with correct data and latency, but the line is not retained.
- R11: rd_ready is a single-cycle pulse. A request is accepted only in IDLE.
- R12: The wait code is captured when a miss is accepted. Changing wait_sel during FETCH does not alter that read's latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request, held until rd_ready |
| rd_addr | input | 18 | Byte address of the read |
| wait_sel | input | 2 | Wait-state code for misses |
| rd_ready | output | 1 | Read data valid, one-cycle pulse |
| rd_data | output | 32 | Read data word |
| hv_en | input | 1 | High-voltage enable level; any change flushes both buffers |
| ilk_wr | input | 1 | Program or erase interlock write pulse |
| ilk_addr | input | 18 | Address of the interlock write |
| arr_req | output | 1 | Array line fetch in progress |
| arr_line_addr | output | 13 | Line address (tag) presented to the array |
| arr_line_data | input | 256 | Full line returned by the array |

## Verification
A hit accepted on one edge shows rd_ready and its word in the very next cycle. A miss shows them w+1 edges later, with arr_req high for each of the fetch cycles in between. A flush or interlock event changes the buffer state on the edge where it is sampled, so it is first visible in the lookup of the next request. The bench drives all inputs on falling edges. On every falling edge it compares rd_ready, rd_data, arr_req and arr_line_addr with a behavioural model that was advanced on the preceding rising edge. The read task also counts falling edges from the request until rd_ready, so each latency is measured in whole clocks and compared with w+2 or 1.

// File: rtl/dlb_pkg.sv
package dlb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RESP  = 2'd2
    } dlb_state_e;

endpackage

// File: rtl/dlb_line_store.sv
module dlb_line_store #(
    parameter int TAG_W  = 13,
    parameter int LINE_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              flush_all,
    input  logic              ilk_en,
    input  logic [TAG_W-1:0]  ilk_tag,
    output logic              valid_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [LINE_W-1:0] line_o
);

    logic              valid_q;
    logic [TAG_W-1:0]  tag_q;
    logic [LINE_W-1:0] line_q;
    logic              ilk_hit;

    assign ilk_hit = ilk_en && valid_q && (tag_q == ilk_tag);

    // Fill wins: a fill is only issued when no event touches the incoming line.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
        end else if (fill_en) begin
            valid_q <= 1'b1;
            tag_q   <= fill_tag;
        end else if (flush_all || ilk_hit) begin
            valid_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (fill_en) begin
            line_q <= fill_line;
        end
    end

    assign valid_o = valid_q;
    assign tag_o   = tag_q;
    assign line_o  = line_q;

endmodule

// File: rtl/dlb_wait_timer.sv
module dlb_wait_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/dlb_word_pick.sv
module dlb_word_pick #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int LINE_W = DATA_W * WORDS
) (
    input  logic [LINE_W-1:0] line,
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] word
);

    logic [DATA_W-1:0] lanes [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_lane
        assign lanes[i] = line[i*DATA_W +: DATA_W];
    end

    assign word = lanes[idx];

endmodule

// File: rtl/dual_line_buf_ctrl.sv
module dual_line_buf_ctrl
    import dlb_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int WAIT_W     = 2,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int WORDS     = LINE_W / DATA_W,
    localparam int BOFF_W    = $clog2(DATA_W / 8),
    localparam int IDX_W     = $clog2(WORDS),
    localparam int TAG_W     = ADDR_W - OFF_W,
    localparam int N_BUF     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [WAIT_W-1:0] wait_sel,
    output logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    input  logic              hv_en,
    input  logic              ilk_wr,
    input  logic [ADDR_W-1:0] ilk_addr,
    output logic              arr_req,
    output logic [TAG_W-1:0]  arr_line_addr,
    input  logic [LINE_W-1:0] arr_line_data
);

    dlb_state_e state, nxt;

    // Request decode
    logic [TAG_W-1:0] rq_tag;
    logic             rq_sel;
    logic [IDX_W-1:0] rq_idx;
    logic [TAG_W-1:0] ilk_tag;

    assign rq_tag  = rd_addr[ADDR_W-1:OFF_W];
    assign rq_sel  = rd_addr[ADDR_W-1];
    assign rq_idx  = rd_addr[OFF_W-1:BOFF_W];
    assign ilk_tag = ilk_addr[ADDR_W-1:OFF_W];

    logic unused_addr_bits;
    assign unused_addr_bits = ^{rd_addr[BOFF_W-1:0], ilk_addr[OFF_W-1:0]};

    // Pending miss context
    logic [TAG_W-1:0] pend_tag;
    logic             pend_sel;
    logic [IDX_W-1:0] pend_idx;
    logic             poison_q;

    // Event detection
    logic hv_q;
    logic hv_toggle;
    logic kill_now;

    assign hv_toggle = hv_en ^ hv_q;
    assign kill_now  = hv_toggle || (ilk_wr && (ilk_tag == pend_tag));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hv_q <= 1'b0;
        else        hv_q <= hv_en;
    end

    // Buffers
    logic [N_BUF-1:0] valid_vec;
    logic [N_BUF-1:0] hit_vec;
    logic [N_BUF-1:0] fill_vec;
    logic [TAG_W-1:0] tag_arr  [N_BUF];
    logic [LINE_W-1:0] line_arr [N_BUF];

    logic timer_zero;
    logic fill_go;
    logic fill_keep;
    logic lookup_hit;
    logic accept;

    assign accept     = (state == ST_IDLE) && rd_req;
    assign lookup_hit = hit_vec[rq_sel];
    assign fill_go    = (state == ST_FETCH) && timer_zero;
    assign fill_keep  = fill_go && !poison_q && !kill_now;

    for (genvar b = 0; b < N_BUF; b++) begin : g_buf
        assign fill_vec[b] = fill_keep && (pend_sel == b[0]);
        assign hit_vec[b]  = valid_vec[b] && (tag_arr[b] == rq_tag);

        dlb_line_store #(
            .TAG_W  (TAG_W),
            .LINE_W (LINE_W)
        ) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .fill_en   (fill_vec[b]),
            .fill_tag  (pend_tag),
            .fill_line (arr_line_data),
            .flush_all (hv_toggle),
            .ilk_en    (ilk_wr),
            .ilk_tag   (ilk_tag),
            .valid_o   (valid_vec[b]),
            .tag_o     (tag_arr[b]),
            .line_o    (line_arr[b])
        );
    end

    // Wait-state timer
    dlb_wait_timer #(
        .CNT_W (WAIT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept && !lookup_hit),
        .load_val (wait_sel),
        .dec      (state == ST_FETCH),
        .zero     (timer_zero)
    );

    // Word selection: buffered line on a hit, array line on a fill
    logic [DATA_W-1:0] hit_word;
    logic [DATA_W-1:0] arr_word;

    dlb_word_pick #(
        .DATA_W (DATA_W),
        .WORDS  (WORDS)
    ) u_pick_buf (
        .line (line_arr[rq_sel]),
        .idx  (rq_idx),
        .word (hit_word)
    );

    dlb_word_pick #(
        .DATA_W (DATA_W),
        .WORDS  (WORDS)
    ) u_pick_arr (
        .line (arr_line_data),
        .idx  (pend_idx),
        .word (arr_word)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (rd_req) nxt = lookup_hit ? ST_RESP : ST_FETCH;
            end
            ST_FETCH: begin
                if (timer_zero) nxt = ST_RESP;
            end
            ST_RESP: begin
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rd_ready      = 1'b0;
        arr_req       = 1'b0;
        arr_line_addr = pend_tag;
        unique case (state)
            ST_IDLE:  ;
            ST_FETCH: arr_req  = 1'b1;
            ST_RESP:  rd_ready = 1'b1;
            default:  ;
        endcase
    end

    // Datapath: pending miss context, poison flag, response word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_tag <= '0;
            pend_sel <= 1'b0;
            pend_idx <= '0;
            poison_q <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (accept && lookup_hit) begin
                rd_data <= hit_word;
            end else if (accept) begin
                pend_tag <= rq_tag;
                pend_sel <= rq_sel;
                pend_idx <= rq_idx;
                poison_q <= 1'b0;
            end else if (fill_go) begin
                rd_data <= arr_word;
            end else if ((state == ST_FETCH) && kill_now) begin
                poison_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dlb_checker.sv
module dlb_checker
    import dlb_pkg::*;
#(
    parameter int WAIT_W = 2,
    parameter int N_BUF  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req,
    input logic             rd_ready,
    input logic             arr_req,
    input logic             hv_en,
    input logic [1:0]       state_i,
    input logic             hit_i,
    input logic [N_BUF-1:0] valid_i,
    input logic [N_BUF-1:0] fill_i
);

    localparam int MAX_FETCH = 2 ** WAIT_W;

    int fetch_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        fetch_run <= 0;
        else if (arr_req)  fetch_run <= fetch_run + 1;
        else               fetch_run <= 0;
    end

    p_fetch_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_run <= MAX_FETCH);

    p_hit_one_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_IDLE && rd_req && hit_i) |=> (rd_ready && !arr_req));

    p_miss_fetches_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_IDLE && rd_req && !hit_i) |=> arr_req);

    p_req_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |-> !rd_ready);

    p_one_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_i));

    p_hv_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_en != $past(hv_en)) |=> (valid_i == '0));

    p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |=> !rd_ready);

endmodule

bind dual_line_buf_ctrl dlb_checker #(
    .WAIT_W (WAIT_W),
    .N_BUF  (N_BUF)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_ready (rd_ready),
    .arr_req  (arr_req),
    .hv_en    (hv_en),
    .state_i  (state),
    .hit_i    (lookup_hit),
    .valid_i  (valid_vec),
    .fill_i   (fill_vec)
);

// File: tb/dual_line_buf_ctrl_bench.sv
module dual_line_buf_ctrl_bench;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req = 1'b0;
    logic [17:0]   rd_addr = '0;
    logic [1:0]    wait_sel = '0;
    logic          rd_ready;
    logic [31:0]   rd_data;
    logic          hv_en = 1'b0;
    logic          ilk_wr = 1'b0;
    logic [17:0]   ilk_addr = '0;
    logic          arr_req;
    logic [12:0]   arr_line_addr;
    logic [255:0]  arr_line_data;

    int n_chk = 0;
    int n_fail = 0;
    string ctx = "R1";

    always #10 clk = ~clk;

    dual_line_buf_ctrl u_dual_line_buf_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_req        (rd_req),
        .rd_addr       (rd_addr),
        .wait_sel      (wait_sel),
        .rd_ready      (rd_ready),
        .rd_data       (rd_data),
        .hv_en         (hv_en),
        .ilk_wr        (ilk_wr),
        .ilk_addr      (ilk_addr),
        .arr_req       (arr_req),
        .arr_line_addr (arr_line_addr),
        .arr_line_data (arr_line_data)
    );

    // Array stub content: unique word per (line, index)
    function automatic logic [31:0] fw(input logic [12:0] t, input logic [2:0] i);
        return {t, i, 16'hC3A5};
    endfunction

    always_comb begin
        for (int i = 0; i < 8; i++) arr_line_data[i*32 +: 32] = fw(arr_line_addr, 3'(i));
    end

    task automatic chk(input bit ok, input string tg, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tg, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge
    int          m_st;
    int          m_cnt;
    bit          m_v [2];
    logic [12:0] m_t [2];
    logic [12:0] m_pt;
    int          m_pb;
    logic [2:0]  m_pw;
    bit          m_poison;
    bit          m_hv;
    logic [31:0] m_data;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_v[0] = 0; m_v[1] = 0;
            m_t[0] = '0; m_t[1] = '0; m_pt = '0; m_pb = 0; m_pw = '0;
            m_poison = 0; m_hv = 0; m_data = '0;
        end else begin
            bit tog, kill, hit;
            int b;
            logic [12:0] t, it;
            tog = (hv_en != m_hv);
            m_hv = hv_en;
            it = ilk_addr[17:5];
            b = int'(rd_addr[17]);
            t = rd_addr[17:5];
            hit = m_v[b] && (m_t[b] == t);
            kill = tog || (ilk_wr && (it == m_pt));
            // events on stored lines
            for (int k = 0; k < 2; k++) begin
                if (tog) m_v[k] = 0;
                if (ilk_wr && m_v[k] && m_t[k] == it) m_v[k] = 0;
            end
            case (m_st)
                0: if (rd_req) begin
                    if (hit) begin
                        m_data = fw(t, rd_addr[4:2]);
                        m_st = 2;
                    end else begin
                        m_cnt = int'(wait_sel); m_pt = t; m_pb = b;
                        m_pw = rd_addr[4:2]; m_poison = 0; m_st = 1;
                    end
                end
                1: begin
                    if (m_cnt == 0) begin
                        m_data = fw(m_pt, m_pw);
                        if (!m_poison && !kill) begin
                            m_v[m_pb] = 1; m_t[m_pb] = m_pt;
                        end
                        m_st = 2;
                    end else begin
                        m_cnt--;
                        if (kill) m_poison = 1;
                    end
                end
                default: m_st = 0;
            endcase
        end
    end

    // Cycle-by-cycle comparison on falling edges
    always @(negedge clk) begin
        if (rst_n) begin
            chk(rd_ready == (m_st == 2), ctx, rd_ready, (m_st == 2));
            chk(arr_req == (m_st == 1), "R6", arr_req, (m_st == 1));
            if (m_st == 2) chk(rd_data == m_data, "R5", rd_data, m_data);
            if (m_st == 1) chk(arr_line_addr == m_pt, "R6", arr_line_addr, m_pt);
        end
    end

    task automatic rd(input logic [17:0] a, input logic [1:0] w, input int exp_lat, input string tg);
        int lat = 0;
        int areq = 0;
        logic [31:0] d;
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a; wait_sel = w;
        do begin
            @(negedge clk);
            lat++;
            if (arr_req) areq++;
        end while (!rd_ready && lat < 20);
        d = rd_data;
        rd_req = 1'b0;
        chk(lat == exp_lat, tg, lat, exp_lat);
        chk(d == fw(a[17:5], a[4:2]), "R5", d, fw(a[17:5], a[4:2]));
        chk(areq == ((exp_lat == 1) ? 0 : exp_lat - 1), "R6", areq, (exp_lat == 1) ? 0 : exp_lat - 1);
        @(negedge clk);
        chk(!rd_ready, "R11", rd_ready, 0);
    endtask

    task automatic ilk(input logic [17:0] a);
        @(negedge clk);
        ilk_wr = 1'b1; ilk_addr = a;
        @(negedge clk);
        ilk_wr = 1'b0;
    endtask

    task automatic flip_hv();
        @(negedge clk);
        hv_en = ~hv_en;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rd_ready == 1'b0, "R1", rd_ready, 0);
        chk(arr_req == 1'b0, "R1", arr_req, 0);
        rst_n = 1'b1;

        // R1: both buffers empty after reset
        ctx = "R1";
        rd(18'h00040, 2'd0, 2, "R1");
        rd(18'h20040, 2'd0, 2, "R1");

        // R4: hit in both halves, R5 word select
        ctx = "R4";
        rd(18'h00044, 2'd3, 1, "R4");
        rd(18'h2005C, 2'd3, 1, "R4");
        ctx = "R5";
        for (int i = 0; i < 8; i++) rd(18'h00040 | 18'(i*4), 2'd1, 1, "R5");

        // R3: every wait code on fresh lines
        ctx = "R3";
        for (int w = 0; w < 4; w++) rd(18'h00400 + 18'(w*32), 2'(w), w + 2, "R3");

        // R2 and R7: halves are independent, same half replaces
        ctx = "R7";
        rd(18'h01000, 2'd1, 3, "R7");
        rd(18'h21000, 2'd2, 4, "R7");
        rd(18'h01008, 2'd2, 1, "R7");
        rd(18'h21004, 2'd2, 1, "R7");
        ctx = "R2";
        rd(18'h01100, 2'd0, 2, "R2");
        rd(18'h21010, 2'd3, 1, "R2");
        rd(18'h01000, 2'd0, 2, "R2");

        // R8: hv change either way flushes both
        ctx = "R8";
        rd(18'h21000, 2'd0, 1, "R8");
        flip_hv();
        rd(18'h01000, 2'd0, 2, "R8");
        rd(18'h21000, 2'd0, 2, "R8");
        flip_hv();
        rd(18'h01004, 2'd1, 3, "R8");
        rd(18'h21004, 2'd1, 3, "R8");

        // R9: interlock write drops only the matching line
        ctx = "R9";
        ilk(18'h01010);
        rd(18'h21000, 2'd0, 1, "R9");
        rd(18'h01000, 2'd2, 4, "R9");
        ilk(18'h03000);
        rd(18'h01000, 2'd2, 1, "R9");
        rd(18'h21000, 2'd2, 1, "R9");

        // R10: event during fetch, data delivered but line dropped
        ctx = "R10";
        fork
            rd(18'h02000, 2'd3, 5, "R10");
            begin repeat (3) @(negedge clk); hv_en = ~hv_en; end
        join
        rd(18'h02000, 2'd0, 2, "R10");
        rd(18'h02000, 2'd0, 1, "R10");
        fork
            rd(18'h22000, 2'd3, 5, "R10");
            begin repeat (3) @(negedge clk); ilk_wr = 1'b1; ilk_addr = 18'h22004;
                  @(negedge clk); ilk_wr = 1'b0; end
        join
        rd(18'h22000, 2'd1, 3, "R10");
        fork
            rd(18'h03000, 2'd2, 4, "R10");
            begin repeat (2) @(negedge clk); ilk_wr = 1'b1; ilk_addr = 18'h09000;
                  @(negedge clk); ilk_wr = 1'b0; end
        join
        rd(18'h03000, 2'd2, 1, "R10");

        // R12: wait code captured at acceptance
        ctx = "R12";
        fork
            rd(18'h04000, 2'd3, 5, "R12");
            begin repeat (2) @(negedge clk); wait_sel = 2'd0; end
        join
        fork
            rd(18'h24000, 2'd0, 2, "R12");
            begin repeat (2) @(negedge clk); wait_sel = 2'd3; end
        join

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule